// File: doc/BRIEF.md
# BCD Real-Time Clock Bridge

This block connects a processor bus to an external clock chip that also holds battery-backed memory. The chip keeps its calendar in packed BCD, one decimal digit per nibble. The processor sees hours, minutes and a day-of-year count in plain binary. On a time request the block runs a short register sequence on the chip bus. A read sequence freezes the chip's calendar, fetches the fields, releases the freeze and publishes the converted values. A write sequence turns the processor's binary hour and minute into BCD and stores them in the chip.

The memory part of the chip is reached through a direct path. The processor drives a full address, a write flag and data. The chip answers in the same cycle, and there is no index register to load first. This path shares the chip bus with the register sequencer and always wins. While a memory access is on the bus, the sequencer holds its current step.

The chip's calendar registers sit in the top eight byte addresses of its space. The control register is at offset 0, minutes at 2, hours at 3, day of month at 5, month at 6 and the two-digit year at 7.

Top module: `rtc_bcd_bridge`

## Requirements
- R1: A read request fetches minutes (offset 2) and hours (offset 3) from the chip as packed BCD and presents them on `minOut`/`hourOut` as binary (BCD 0x12 reads as 12).
- R2: A read also yields `dayOfYear` = days of all earlier months + day of month, using month (offset 6) and day (offset 5) in BCD, so 1 January is 1 and 31 December of a common year is 365.
- R3: When the BCD year (offset 7) as a number is divisible by four, February has 29 days and dates after February gain one day (31 December gives 366; year 00 counts as leap).
- R4: A write request converts `tmHourIn`/`tmMinIn` to packed BCD and stores them at offsets 3 and 2; a write sequence leaves `hourOut`, `minOut` and `dayOfYear` unchanged.
- R5: A written hour above 23 is stored as 0x23 and a written minute above 59 as 0x59.
- R6: A read sequence writes 0x40 (read freeze) to the control register (offset 0) before any field is read and writes 0x00 after the last. A write sequence writes 0x80 (write freeze) first and 0x00 last. No other control-register writes occur.
- R7: While `nvSel` is high, `chipAddr`, `chipWdata` and `chipWe` follow `nvAddr`, `nvWdata` and `nvWr`, `chipOe` is the inverse of `nvWr`, and `nvRdata` returns the chip data in the same cycle.
- R8: A memory access during a register sequence takes the bus. The sequence stalls one cycle per access cycle and then completes with correct results. An idle read lasts 8 busy cycles, and three access cycles make it 11.
- R9: `busy` is high from the cycle after a request is accepted until the sequence ends: 8 cycles for a read, 5 for a write. A request made while busy is held and started once the current sequence ends. The published outputs change only at the end of a read sequence.
- R10: During reset `busy`, `tmDone` and `chipWe` are low and `hourOut`, `minOut`, `dayOfYear` are zero.
- R11: `tmDone` is high for exactly one cycle, the first cycle after `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nvSel | input | 1 | Direct memory access this cycle |
| nvWr | input | 1 | Direct access is a write |
| nvAddr | input | ADDR_W | Direct access byte address |
| nvWdata | input | 8 | Direct access write data |
| nvRdata | output | 8 | Direct access read data |
| tmReq | input | 1 | One-cycle time request |
| tmWr | input | 1 | Request sets time (1) or reads it (0) |
| tmHourIn | input | 8 | Binary hour for a set request |
| tmMinIn | input | 8 | Binary minute for a set request |
| busy | output | 1 | Register sequence in progress |
| tmDone | output | 1 | Sequence finished pulse |
| hourOut | output | 5 | Binary hour, 0 to 23 |
| minOut | output | 6 | Binary minute, 0 to 59 |
| dayOfYear | output | 9 | Day of year, 1 to 366 |
| chipAddr | output | ADDR_W | Chip address |
| chipWdata | output | 8 | Chip write data |
| chipWe | output | 1 | Chip write strobe |
| chipOe | output | 1 | Chip output enable |
| chipRdata | input | 8 | Chip read data |

## Verification
A direct memory access and a step of the register sequence can both want the chip bus in the same cycle. The bench starts a read and then, in the next three cycles, holds `nvSel` high. It writes a memory byte and reads it back through the direct path during the stall. It then checks three things: the stall lengthens the busy window from 8 to 11 cycles, the memory byte survives intact, and the published time still matches the loaded calendar. A second collision is a new request arriving while a sequence runs. The bench checks that this request is held, starts after a one-cycle idle gap, and stores its BCD values without disturbing the outputs of the read that preceded it.

// File: rtl/rtc_bridge_pkg.sv
package rtc_bridge_pkg;

  // calendar registers occupy the top REG_SPAN addresses of the chip
  localparam int REG_SPAN = 8;
  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_MIN  = 3'd2;
  localparam logic [2:0] OFS_HOUR = 3'd3;
  localparam logic [2:0] OFS_DATE = 3'd5;
  localparam logic [2:0] OFS_MON  = 3'd6;
  localparam logic [2:0] OFS_YEAR = 3'd7;

  // control register freeze bits
  localparam logic [7:0] FREEZE_READ  = 8'h40;
  localparam logic [7:0] FREEZE_WRITE = 8'h80;

  localparam int HOUR_MAX = 23;
  localparam int MIN_MAX  = 59;
  localparam int DOY_W    = 9;

  typedef enum logic [2:0] {
    WS_ZERO,
    WS_RDFREEZE,
    WS_WRFREEZE,
    WS_MIN,
    WS_HOUR
  } wsel_e;

  typedef struct packed {
    logic  capMin;
    logic  capHour;
    logic  capDate;
    logic  capMon;
    logic  capYear;
    logic  publish;
    logic  loadNew;
    logic  loadPend;
    logic  savePend;
    wsel_e wSel;
  } strobe_t;

endpackage

// File: rtl/rtc_bridge_ctrl.sv
module rtc_bridge_ctrl
  import rtc_bridge_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tmReq,
  input  logic       tmWr,
  input  logic       nvSel,
  output strobe_t    stb,
  output logic [2:0] regOfs,
  output logic       fsmWe,
  output logic       fsmOe,
  output logic       busy,
  output logic       tmDone
);

  typedef enum logic [3:0] {
    S_IDLE, S_RD_LOCK, S_RD_MIN, S_RD_HOUR, S_RD_DATE, S_RD_MON, S_RD_YEAR,
    S_RD_UNLOCK, S_WR_LOCK, S_WR_MIN, S_WR_HOUR, S_WR_UNLOCK, S_FIN
  } state_e;

  state_e stateR, nextStep;
  logic   pendValidR, pendWrR, isReadR, doneR;
  logic   idle, startPend, startNew, startWr, onBus, advance;
  logic   rawWe, capMinC, capHourC, capDateC, capMonC, capYearC;

  assign idle      = (stateR == S_IDLE);
  assign startPend = idle && pendValidR;
  assign startNew  = idle && !pendValidR && tmReq;
  assign startWr   = startPend ? pendWrR : tmWr;

  // per-step bus activity and successor
  always_comb begin
    regOfs   = OFS_CTRL;
    rawWe    = 1'b0;
    fsmOe    = 1'b0;
    onBus    = 1'b1;
    nextStep = stateR;
    stb.wSel = WS_ZERO;
    capMinC  = 1'b0;
    capHourC = 1'b0;
    capDateC = 1'b0;
    capMonC  = 1'b0;
    capYearC = 1'b0;
    case (stateR)
      S_RD_LOCK:   begin rawWe = 1'b1; stb.wSel = WS_RDFREEZE; nextStep = S_RD_MIN; end
      S_RD_MIN:    begin regOfs = OFS_MIN;  fsmOe = 1'b1; capMinC  = 1'b1; nextStep = S_RD_HOUR; end
      S_RD_HOUR:   begin regOfs = OFS_HOUR; fsmOe = 1'b1; capHourC = 1'b1; nextStep = S_RD_DATE; end
      S_RD_DATE:   begin regOfs = OFS_DATE; fsmOe = 1'b1; capDateC = 1'b1; nextStep = S_RD_MON; end
      S_RD_MON:    begin regOfs = OFS_MON;  fsmOe = 1'b1; capMonC  = 1'b1; nextStep = S_RD_YEAR; end
      S_RD_YEAR:   begin regOfs = OFS_YEAR; fsmOe = 1'b1; capYearC = 1'b1; nextStep = S_RD_UNLOCK; end
      S_RD_UNLOCK: begin rawWe = 1'b1; nextStep = S_FIN; end
      S_WR_LOCK:   begin rawWe = 1'b1; stb.wSel = WS_WRFREEZE; nextStep = S_WR_MIN; end
      S_WR_MIN:    begin regOfs = OFS_MIN;  rawWe = 1'b1; stb.wSel = WS_MIN;  nextStep = S_WR_HOUR; end
      S_WR_HOUR:   begin regOfs = OFS_HOUR; rawWe = 1'b1; stb.wSel = WS_HOUR; nextStep = S_WR_UNLOCK; end
      S_WR_UNLOCK: begin rawWe = 1'b1; nextStep = S_FIN; end
      S_FIN:       begin onBus = 1'b0; nextStep = S_IDLE; end
      default:     begin onBus = 1'b0; nextStep = S_IDLE; end
    endcase
  end

  // a direct memory access owns the bus; bus steps wait for it
  assign advance = !(onBus && nvSel);

  assign fsmWe       = rawWe && advance;
  assign stb.capMin  = capMinC && advance;
  assign stb.capHour = capHourC && advance;
  assign stb.capDate = capDateC && advance;
  assign stb.capMon  = capMonC && advance;
  assign stb.capYear = capYearC && advance;
  assign stb.publish = (stateR == S_FIN) && isReadR;
  assign stb.loadNew  = startNew;
  assign stb.loadPend = startPend;
  assign stb.savePend = tmReq && !startNew;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateR     <= S_IDLE;
      pendValidR <= 1'b0;
      pendWrR    <= 1'b0;
      isReadR    <= 1'b0;
      doneR      <= 1'b0;
    end else begin
      doneR <= (stateR == S_FIN);
      if (startPend || startNew) begin
        stateR  <= startWr ? S_WR_LOCK : S_RD_LOCK;
        isReadR <= !startWr;
      end else if (!idle && advance) begin
        stateR <= nextStep;
      end
      if (stb.savePend) begin
        pendValidR <= 1'b1;
        pendWrR    <= tmWr;
      end else if (startPend) begin
        pendValidR <= 1'b0;
      end
    end
  end

  assign busy   = !idle;
  assign tmDone = doneR;

endmodule

// File: rtl/rtc_bridge_dpath.sv
module rtc_bridge_dpath
  import rtc_bridge_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [7:0]       chipRdata,
  input  logic [7:0]       tmHourIn,
  input  logic [7:0]       tmMinIn,
  output logic [7:0]       fsmWdata,
  output logic [4:0]       hourOut,
  output logic [5:0]       minOut,
  output logic [DOY_W-1:0] dayOfYear
);

  logic [7:0] capMinR, capHourR, capDateR, capMonR, capYearR;
  logic [7:0] wrHourR, wrMinR, pendHourR, pendMinR;
  logic [4:0] hourOutR;
  logic [5:0] minOutR;
  logic [DOY_W-1:0] doyR, doyC;
  logic [6:0] hourClamp, minClamp, monBin, dayBin, yearBin;
  logic [3:0] monIdx;
  logic       leapYear;

  function automatic logic [6:0] bcdToBin(input logic [7:0] b);
    return 7'(int'(b[7:4]) * 10 + int'(b[3:0]));
  endfunction

  function automatic logic [7:0] binToBcd(input logic [6:0] v);
    return {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  function automatic int monthLen(input int m);
    case (m)
      2:             return 28;
      4, 6, 9, 11:   return 30;
      default:       return 31;
    endcase
  endfunction

  function automatic logic [DOY_W-1:0] daysBefore(input logic [3:0] m);
    int sum;
    sum = 0;
    for (int i = 1; i < 12; i++) begin
      if (i < int'(m)) sum += monthLen(i);
    end
    return DOY_W'(sum);
  endfunction

  // saturate binary write values before conversion
  assign hourClamp = (wrHourR > 8'(HOUR_MAX)) ? 7'(HOUR_MAX) : wrHourR[6:0];
  assign minClamp  = (wrMinR  > 8'(MIN_MAX))  ? 7'(MIN_MAX)  : wrMinR[6:0];

  always_comb begin
    case (stb.wSel)
      WS_RDFREEZE: fsmWdata = FREEZE_READ;
      WS_WRFREEZE: fsmWdata = FREEZE_WRITE;
      WS_MIN:      fsmWdata = binToBcd(minClamp);
      WS_HOUR:     fsmWdata = binToBcd(hourClamp);
      default:     fsmWdata = 8'h00;
    endcase
  end

  // day-of-year from captured month, day and year
  assign monBin   = bcdToBin(capMonR);
  assign dayBin   = bcdToBin(capDateR);
  assign yearBin  = bcdToBin(capYearR);
  assign monIdx   = (monBin == 7'd0) ? 4'd1 : (monBin > 7'd12) ? 4'd12 : monBin[3:0];
  assign leapYear = (yearBin[1:0] == 2'b00);
  assign doyC     = daysBefore(monIdx) + DOY_W'(dayBin)
                  + DOY_W'(leapYear && (monIdx > 4'd2));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capMinR   <= '0;
      capHourR  <= '0;
      capDateR  <= '0;
      capMonR   <= '0;
      capYearR  <= '0;
      wrHourR   <= '0;
      wrMinR    <= '0;
      pendHourR <= '0;
      pendMinR  <= '0;
      hourOutR  <= '0;
      minOutR   <= '0;
      doyR      <= '0;
    end else begin
      if (stb.capMin)  capMinR  <= chipRdata;
      if (stb.capHour) capHourR <= chipRdata;
      if (stb.capDate) capDateR <= chipRdata;
      if (stb.capMon)  capMonR  <= chipRdata;
      if (stb.capYear) capYearR <= chipRdata;
      if (stb.loadPend) begin
        wrHourR <= pendHourR;
        wrMinR  <= pendMinR;
      end else if (stb.loadNew) begin
        wrHourR <= tmHourIn;
        wrMinR  <= tmMinIn;
      end
      if (stb.savePend) begin
        pendHourR <= tmHourIn;
        pendMinR  <= tmMinIn;
      end
      if (stb.publish) begin
        hourOutR <= 5'(bcdToBin(capHourR));
        minOutR  <= 6'(bcdToBin(capMinR));
        doyR     <= doyC;
      end
    end
  end

  assign hourOut   = hourOutR;
  assign minOut    = minOutR;
  assign dayOfYear = doyR;

endmodule

// File: rtl/rtc_bcd_bridge.sv
module rtc_bcd_bridge
  import rtc_bridge_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nvSel,
  input  logic              nvWr,
  input  logic [ADDR_W-1:0] nvAddr,
  input  logic [7:0]        nvWdata,
  output logic [7:0]        nvRdata,
  input  logic              tmReq,
  input  logic              tmWr,
  input  logic [7:0]        tmHourIn,
  input  logic [7:0]        tmMinIn,
  output logic              busy,
  output logic              tmDone,
  output logic [4:0]        hourOut,
  output logic [5:0]        minOut,
  output logic [8:0]        dayOfYear,
  output logic [ADDR_W-1:0] chipAddr,
  output logic [7:0]        chipWdata,
  output logic              chipWe,
  output logic              chipOe,
  input  logic [7:0]        chipRdata
);

  localparam int OFS_W = $clog2(REG_SPAN);
  localparam logic [ADDR_W-OFS_W-1:0] REG_PAGE = '1;

  strobe_t    stb;
  logic [2:0] regOfs;
  logic       fsmWe, fsmOe;
  logic [7:0] fsmWdata;

  rtc_bridge_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .tmReq  (tmReq),
    .tmWr   (tmWr),
    .nvSel  (nvSel),
    .stb    (stb),
    .regOfs (regOfs),
    .fsmWe  (fsmWe),
    .fsmOe  (fsmOe),
    .busy   (busy),
    .tmDone (tmDone)
  );

  rtc_bridge_dpath dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .chipRdata (chipRdata),
    .tmHourIn  (tmHourIn),
    .tmMinIn   (tmMinIn),
    .fsmWdata  (fsmWdata),
    .hourOut   (hourOut),
    .minOut    (minOut),
    .dayOfYear (dayOfYear)
  );

  // shared chip bus: direct memory access has priority
  assign chipAddr  = nvSel ? nvAddr  : {REG_PAGE, regOfs};
  assign chipWdata = nvSel ? nvWdata : fsmWdata;
  assign chipWe    = nvSel ? nvWr    : fsmWe;
  assign chipOe    = nvSel ? !nvWr   : fsmOe;
  assign nvRdata   = chipRdata;

endmodule

// File: rtl/rtc_bcd_bridge_chk.sv
module rtc_bcd_bridge_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              nvSel,
  input logic              nvWr,
  input logic [ADDR_W-1:0] nvAddr,
  input logic [ADDR_W-1:0] chipAddr,
  input logic              chipWe,
  input logic              busy,
  input logic              tmDone,
  input logic [4:0]        hourOut,
  input logic [5:0]        minOut,
  input logic [8:0]        dayOfYear
);

  AST_NV_PASS: assert property (@(posedge clk) disable iff (!rstN)
    nvSel |-> (chipAddr == nvAddr) && (chipWe == nvWr)); // R7

  AST_STALL_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && nvSel && !tmDone && $past(busy)) |=> busy); // R8

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !nvSel) |-> !chipWe); // R9

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    tmDone |=> !tmDone); // R11

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tmDone) |-> (!busy && $past(busy))); // R11

  AST_OUT_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(hourOut) || !$stable(minOut) || !$stable(dayOfYear)) |-> tmDone); // R9

  AST_DOY_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    dayOfYear <= 9'd366); // R2

endmodule

bind rtc_bcd_bridge rtc_bcd_bridge_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .nvSel     (nvSel),
  .nvWr      (nvWr),
  .nvAddr    (nvAddr),
  .chipAddr  (chipAddr),
  .chipWe    (chipWe),
  .busy      (busy),
  .tmDone    (tmDone),
  .hourOut   (hourOut),
  .minOut    (minOut),
  .dayOfYear (dayOfYear)
);

// File: tb/rtc_bcd_bridge_tb_top.sv
module rtc_bcd_bridge_tb_top;

  localparam int ADDR_W = 11;
  localparam int TOP_A  = (1 << ADDR_W) - 8;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(TOP_A + 0);
  localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(TOP_A + 2);
  localparam logic [ADDR_W-1:0] A_HOUR = ADDR_W'(TOP_A + 3);
  localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(TOP_A + 5);
  localparam logic [ADDR_W-1:0] A_MON  = ADDR_W'(TOP_A + 6);
  localparam logic [ADDR_W-1:0] A_YEAR = ADDR_W'(TOP_A + 7);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rstN, nvSel, nvWr, tmReq, tmWr;
  logic [ADDR_W-1:0] nvAddr, chipAddr;
  logic [7:0]        nvWdata, nvRdata, tmHourIn, tmMinIn, chipWdata, chipRdata;
  logic              busy, tmDone, chipWe, chipOe;
  logic [4:0]        hourOut;
  logic [5:0]        minOut;
  logic [8:0]        dayOfYear;

  rtc_bcd_bridge #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .nvSel(nvSel), .nvWr(nvWr), .nvAddr(nvAddr),
    .nvWdata(nvWdata), .nvRdata(nvRdata), .tmReq(tmReq), .tmWr(tmWr),
    .tmHourIn(tmHourIn), .tmMinIn(tmMinIn), .busy(busy), .tmDone(tmDone),
    .hourOut(hourOut), .minOut(minOut), .dayOfYear(dayOfYear),
    .chipAddr(chipAddr), .chipWdata(chipWdata), .chipWe(chipWe),
    .chipOe(chipOe), .chipRdata(chipRdata)
  );

  // clock chip model: asynchronous read, clocked write, control-write log
  logic [7:0] chipMem [0:(1<<ADDR_W)-1];
  logic [7:0] ctrlLog [0:63];
  int ctrlCnt = 0;
  assign chipRdata = chipMem[chipAddr];
  always @(posedge clk) begin
    if (chipWe) begin
      chipMem[chipAddr] <= chipWdata;
      if (chipAddr == A_CTRL) begin
        ctrlLog[ctrlCnt[5:0]] <= chipWdata;
        ctrlCnt <= ctrlCnt + 1;
      end
    end
  end

  int nChecks = 0;
  int nErr = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    nvSel = 1'b1; nvWr = 1'b1; nvAddr = a; nvWdata = d;
    @(negedge clk);
    nvSel = 1'b0; nvWr = 1'b0;
  endtask

  task automatic peek(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    nvSel = 1'b1; nvWr = 1'b0; nvAddr = a;
    #1 d = nvRdata;
    @(negedge clk);
    nvSel = 1'b0;
  endtask

  task automatic request(input logic wr, input logic [7:0] h, input logic [7:0] m);
    tmReq = 1'b1; tmWr = wr; tmHourIn = h; tmMinIn = m;
    @(negedge clk);
    tmReq = 1'b0;
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic loadCal(input logic [7:0] mi, input logic [7:0] ho,
                         input logic [7:0] da, input logic [7:0] mo, input logic [7:0] ye);
    poke(A_MIN, mi); poke(A_HOUR, ho); poke(A_DATE, da); poke(A_MON, mo); poke(A_YEAR, ye);
  endtask

  // {min, hour, date, month, year} in BCD, then expected min, hour, day-of-year
  typedef struct packed {
    logic [7:0] mi, ho, da, mo, ye;
    logic [7:0] eMin, eHour;
    logic [8:0] eDoy;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{8'h12, 8'h12, 8'h01, 8'h01, 8'h23, 8'd12, 8'd12, 9'd1},
    '{8'h59, 8'h23, 8'h31, 8'h12, 8'h23, 8'd59, 8'd23, 9'd365},
    '{8'h00, 8'h00, 8'h31, 8'h12, 8'h24, 8'd0,  8'd0,  9'd366},
    '{8'h30, 8'h07, 8'h29, 8'h02, 8'h24, 8'd30, 8'd7,  9'd60},
    '{8'h05, 8'h19, 8'h01, 8'h03, 8'h24, 8'd5,  8'd19, 9'd61},
    '{8'h45, 8'h10, 8'h01, 8'h03, 8'h23, 8'd45, 8'd10, 9'd60},
    '{8'h07, 8'h08, 8'h15, 8'h06, 8'h00, 8'd7,  8'd8,  9'd167},
    '{8'h34, 8'h21, 8'h28, 8'h02, 8'h99, 8'd34, 8'd21, 9'd59}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nErr++;
      nChecks++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    int n, s;
    logic [7:0] d;
    rstN = 1'b0; nvSel = 1'b0; nvWr = 1'b0; nvAddr = '0; nvWdata = '0;
    tmReq = 1'b0; tmWr = 1'b0; tmHourIn = '0; tmMinIn = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 busy", 16'(busy), 16'd0);
    check("R10 tmDone", 16'(tmDone), 16'd0);
    check("R10 chipWe", 16'(chipWe), 16'd0);
    check("R10 hourOut", 16'(hourOut), 16'd0);
    check("R10 minOut", 16'(minOut), 16'd0);
    check("R10 dayOfYear", 16'(dayOfYear), 16'd0);
    rstN = 1'b1;
    @(negedge clk);

    // table walk: R1 conversion, R2/R3 day-of-year
    for (int i = 0; i < 8; i++) begin
      loadCal(VECS[i].mi, VECS[i].ho, VECS[i].da, VECS[i].mo, VECS[i].ye);
      s = ctrlCnt;
      request(1'b0, 8'd0, 8'd0);
      waitIdle(n);
      check("R1 minOut", 16'(minOut), 16'(VECS[i].eMin));
      check("R1 hourOut", 16'(hourOut), 16'(VECS[i].eHour));
      check("R2 R3 dayOfYear", 16'(dayOfYear), 16'(VECS[i].eDoy));
      if (i == 0) begin
        check("R9 read busy cycles", 16'(n), 16'd8);
        check("R11 tmDone after busy", 16'(tmDone), 16'd1);
        check("R6 read ctrl writes", 16'(ctrlCnt - s), 16'd2);
        check("R6 read freeze first", 16'(ctrlLog[s[5:0]]), 16'h40);
        check("R6 read release last", 16'(ctrlLog[6'(s + 1)]), 16'h00);
        @(negedge clk);
        check("R11 tmDone one cycle", 16'(tmDone), 16'd0);
      end
    end

    // R4 write conversion, outputs untouched
    s = ctrlCnt;
    request(1'b1, 8'd9, 8'd45);
    waitIdle(n);
    check("R9 write busy cycles", 16'(n), 16'd5);
    check("R4 outputs kept hour", 16'(hourOut), 16'd21);
    check("R4 outputs kept doy", 16'(dayOfYear), 16'd59);
    check("R6 write ctrl writes", 16'(ctrlCnt - s), 16'd2);
    check("R6 write freeze first", 16'(ctrlLog[s[5:0]]), 16'h80);
    check("R6 write release last", 16'(ctrlLog[6'(s + 1)]), 16'h00);
    peek(A_MIN, d);  check("R4 min bcd", 16'(d), 16'h45);
    peek(A_HOUR, d); check("R4 hour bcd", 16'(d), 16'h09);

    // R5 clamping at and beyond the limits
    request(1'b1, 8'd24, 8'd60);
    waitIdle(n);
    peek(A_MIN, d);  check("R5 min 60 clamp", 16'(d), 16'h59);
    peek(A_HOUR, d); check("R5 hour 24 clamp", 16'(d), 16'h23);
    request(1'b1, 8'd0, 8'd0);
    waitIdle(n);
    peek(A_HOUR, d); check("R4 hour zero", 16'(d), 16'h00);
    request(1'b1, 8'd200, 8'd77);
    waitIdle(n);
    peek(A_MIN, d);  check("R5 min 77 clamp", 16'(d), 16'h59);
    peek(A_HOUR, d); check("R5 hour 200 clamp", 16'(d), 16'h23);

    // R7 direct access while idle
    poke(ADDR_W'(9), 8'h5A);
    nvSel = 1'b1; nvWr = 1'b0; nvAddr = ADDR_W'(9);
    #1;
    check("R7 read data", 16'(nvRdata), 16'h5A);
    check("R7 address", 16'(chipAddr), 16'd9);
    check("R7 output enable", 16'(chipOe), 16'd1);
    @(negedge clk);
    nvSel = 1'b0;

    // R8 collision: direct access during a read sequence
    loadCal(8'h05, 8'h19, 8'h01, 8'h03, 8'h24);
    request(1'b0, 8'd0, 8'd0);
    n = 0;
    nvSel = 1'b1; nvWr = 1'b1; nvAddr = ADDR_W'(7); nvWdata = 8'hA5;
    n++;
    @(negedge clk);
    nvWr = 1'b0;
    for (int k = 0; k < 2; k++) begin
      #1;
      check("R8 stalled read data", 16'(nvRdata), 16'hA5);
      check("R7 stalled address", 16'(chipAddr), 16'd7);
      n++;
      @(negedge clk);
    end
    nvSel = 1'b0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
    check("R8 stalled busy cycles", 16'(n), 16'd11);
    check("R8 minOut after stall", 16'(minOut), 16'd5);
    check("R8 hourOut after stall", 16'(hourOut), 16'd19);
    check("R8 doy after stall", 16'(dayOfYear), 16'd61);

    // R9 request while busy is held and run afterwards
    loadCal(8'h12, 8'h12, 8'h01, 8'h01, 8'h23);
    request(1'b0, 8'd0, 8'd0);
    request(1'b1, 8'd5, 8'd30);
    waitIdle(n);
    check("R9 read before held write hour", 16'(hourOut), 16'd12);
    check("R9 read before held write doy", 16'(dayOfYear), 16'd1);
    @(negedge clk);
    check("R9 held request started", 16'(busy), 16'd1);
    waitIdle(n);
    peek(A_MIN, d);  check("R9 held write min", 16'(d), 16'h30);
    peek(A_HOUR, d); check("R9 held write hour", 16'(d), 16'h05);
    check("R9 outputs kept", 16'(minOut), 16'd12);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule